// File: doc/BRIEF.md
# Divider Setting Loader

This block keeps the setting that a frequency synthesizer's divider and mux logic work from: a 9-bit feedback ratio, a 2-bit output divide code and two test-select bits. The setting can come from dedicated pins under an active-low parallel strobe, or from a 14-bit serial frame. The serial frame is shifted in on a serial clock and moved into the active setting by a load strobe.

All strobe and serial inputs are sampled by one system clock. A rising serial clock is found by comparing each sample with the one before it. The active setting and a flag are registered. The flag shows whether the last source in effect was the parallel pins. Any change at the inputs shows at the outputs just after the system clock edge that samples it.

Top module: `divcfg_loader`

## Requirements
- R1: A synchronous reset sets the feedback ratio output to 32 (only bit 5 set), the output divide code and test bits to 0, and the parallel flag to 0. It also clears the shift register, so a serial load right after reset gives a ratio of 0.
- R2: While `par_load_n` is sampled low, `ratio_out` and `odiv_out` follow `ratio_pins` and `odiv_pins` one system clock later.
- R3: Once `par_load_n` is high and `ser_load` is low, the outputs hold the pin values from the last cycle the strobe was low, whatever the pins do afterwards.
- R4: Each rising edge of `ser_clk` shifts `ser_data` into the shift register. After 14 edges, the first bit shifted is the high test bit, then the low test bit, then a null slot, then the divide code high bit and low bit, then ratio bits 8 down to 0. The null slot never reaches any output.
- R5: With `ser_load` low, serial shifting leaves the outputs unchanged. After `ser_load` falls, the values loaded stay held.
- R6: While `ser_load` is high and `par_load_n` is high, the outputs show the shift register contents, decoded as in R4. This includes every new serial-clock edge.
- R7: Parallel-mode activity does not change the contents of the shift register.
- R8: `par_mode` is 1 after any cycle with `par_load_n` low. It is 0 after a serial load, meaning a cycle with `ser_load` high and `par_load_n` high.
- R9: When `par_load_n` is low and `ser_load` is high in the same cycle, the parallel pins win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe, transparent while high |
| par_load_n | input | 1 | Parallel strobe, active low |
| ratio_pins | input | 9 | Parallel feedback ratio |
| odiv_pins | input | 2 | Parallel output divide code |
| ratio_out | output | 9 | Active feedback ratio |
| odiv_out | output | 2 | Active output divide code |
| test_out | output | 2 | Active test-select bits |
| par_mode | output | 1 | Parallel source in effect |

## Verification
The bench sends frames with the null slot set opposite to its neighbours. A one-slot misalignment in the frame decode would then show up in the divide code or the test bits. It changes the pins after the parallel strobe rises, so a design that kept following the pins would fail R3. It also strobes the parallel pins between shifting a frame and loading it, which catches a shift register that parallel activity disturbs. The bench drives both strobes at once, so a design with the wrong priority would show the serial value. It also clocks bits while the serial strobe is held high; a design lacking the transparent path would show stale values.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    localparam int RATIO_W = 9;
    localparam int ODIV_W  = 2;
    localparam int TEST_W  = 2;
    localparam int FRAME_W = TEST_W + 1 + ODIV_W + RATIO_W;

    typedef struct packed {
        logic [TEST_W-1:0]  test;
        logic [ODIV_W-1:0]  odiv;
        logic [RATIO_W-1:0] ratio;
    } divcfg_t;

    // Frame as held in the shift register: test bits oldest, then the
    // null slot, then divide code, then ratio with bit 0 newest.
    function automatic divcfg_t frame_decode(input logic [FRAME_W-1:0] f);
        divcfg_t c;
        c.test  = f[FRAME_W-1 -: TEST_W];
        c.odiv  = f[RATIO_W +: ODIV_W];
        c.ratio = f[RATIO_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/divcfg_rise_det.sv
module divcfg_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] sh_d,
    output logic [FRAME_W-1:0] sh_q
);
    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[FRAME_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    // R4: each detected serial edge moves the frame by one place
    a_r4_shift_order: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sh_q[0] == $past(din)) &&
                     (sh_q[FRAME_W-1:1] == $past(sh_q[FRAME_W-2:0])));

    // R7: without a serial edge the register keeps its contents
    a_r7_shift_quiet: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold
    import divcfg_pkg::*;
#(
    parameter logic [RATIO_W-1:0] RATIO_RST = 9'h020
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               par_sel,
    input  logic               ser_sel,
    input  logic [RATIO_W-1:0] par_ratio,
    input  logic [ODIV_W-1:0]  par_odiv,
    input  divcfg_t            ser_cfg,
    output divcfg_t            cfg_q,
    output logic               par_mode_q
);
    typedef struct packed {
        divcfg_t cfg;
        logic    par_mode;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (par_sel) begin
            st_d.cfg.ratio = par_ratio;
            st_d.cfg.odiv  = par_odiv;
            st_d.par_mode  = 1'b1;
        end else if (ser_sel) begin
            st_d.cfg      = ser_cfg;
            st_d.par_mode = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cfg.ratio <= RATIO_RST;
            st_q.cfg.odiv  <= '0;
            st_q.cfg.test  <= '0;
            st_q.par_mode  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q      = st_q.cfg;
    assign par_mode_q = st_q.par_mode;

    a_r1_reset_val: assert property (@(posedge clk)
        rst |=> (cfg_q.ratio == RATIO_RST) && (cfg_q.odiv == '0) &&
                (cfg_q.test == '0) && !par_mode_q);

    a_r2_par_follow: assert property (@(posedge clk) disable iff (rst)
        par_sel |=> (cfg_q.ratio == $past(par_ratio)) &&
                    (cfg_q.odiv == $past(par_odiv)));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && !ser_sel) |=> $stable(cfg_q) && $stable(par_mode_q));

    a_r8_flag_par: assert property (@(posedge clk) disable iff (rst)
        par_sel |=> par_mode_q);

    a_r8_flag_ser: assert property (@(posedge clk) disable iff (rst)
        (ser_sel && !par_sel) |=> !par_mode_q);

    // R9: parallel pins win over a simultaneous serial strobe
    a_r9_par_first: assert property (@(posedge clk) disable iff (rst)
        (par_sel && ser_sel) |=> (cfg_q.ratio == $past(par_ratio)));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter logic [RATIO_W-1:0] RATIO_RST = 9'h020
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_load,
    input  logic               par_load_n,
    input  logic [RATIO_W-1:0] ratio_pins,
    input  logic [ODIV_W-1:0]  odiv_pins,
    output logic [RATIO_W-1:0] ratio_out,
    output logic [ODIV_W-1:0]  odiv_out,
    output logic [TEST_W-1:0]  test_out,
    output logic               par_mode
);
    logic               sclk_rise;
    logic [FRAME_W-1:0] sh_d, sh_q;
    divcfg_t            cfg_q;

    divcfg_rise_det #(.W(1)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (ser_clk),
        .rise (sclk_rise)
    );

    divcfg_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .din      (ser_data),
        .sh_d     (sh_d),
        .sh_q     (sh_q)
    );

    divcfg_hold #(.RATIO_RST(RATIO_RST)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .par_sel    (!par_load_n),
        .ser_sel    (ser_load),
        .par_ratio  (ratio_pins),
        .par_odiv   (odiv_pins),
        .ser_cfg    (frame_decode(sh_d)),
        .cfg_q      (cfg_q),
        .par_mode_q (par_mode)
    );

    assign ratio_out = cfg_q.ratio;
    assign odiv_out  = cfg_q.odiv;
    assign test_out  = cfg_q.test;

    // R6: while the serial strobe is high the outputs track the shifter
    a_r6_transparent: assert property (@(posedge clk) disable iff (rst)
        (par_load_n && ser_load) |=>
            (ratio_out == sh_q[RATIO_W-1:0]) &&
            (odiv_out == sh_q[RATIO_W +: ODIV_W]) &&
            (test_out == sh_q[FRAME_W-1 -: TEST_W]));
endmodule

// File: tb/divcfg_loader_test.sv
module divcfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {odiv, ratio}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 9'd8}, {2'd1, 9'd28}, {2'd2, 9'd17},
        {2'd3, 9'd58}, {2'd0, 9'd511}, {2'd3, 9'd0}
    };

    logic clk = 1'b0;
    logic rst, ser_clk, ser_data, ser_load, par_load_n;
    logic [8:0] ratio_pins, ratio_out;
    logic [1:0] odiv_pins, odiv_out, test_out;
    logic par_mode;
    logic [13:0] sh = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divcfg_loader uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load_n(par_load_n),
        .ratio_pins(ratio_pins), .odiv_pins(odiv_pins),
        .ratio_out(ratio_out), .odiv_out(odiv_out),
        .test_out(test_out), .par_mode(par_mode)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req, input logic [1:0] t,
                           input logic [1:0] n, input logic [8:0] m);
        chk({req, " ratio"}, int'(ratio_out), int'(m));
        chk({req, " odiv"}, int'(odiv_out), int'(n));
        chk({req, " test"}, int'(test_out), int'(t));
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        ser_clk = 1'b1;
        cyc();
        ser_clk = 1'b0;
        cyc();
        sh = {sh[12:0], b};
    endtask

    task automatic send_frame(input logic [1:0] t, input logic nul,
                              input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, nul, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ser_clk = 0; ser_data = 0; ser_load = 0;
        par_load_n = 1'b1; ratio_pins = '0; odiv_pins = '0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        chk_cfg("R1 reset", 2'd0, 2'd0, 9'd32);
        chk("R1 reset flag", int'(par_mode), 0);

        for (int i = 0; i < NVEC; i++) begin
            par_load_n = 1'b0;
            odiv_pins = VEC[i][10:9];
            ratio_pins = VEC[i][8:0];
            cyc();
            chk("R2 ratio follow", int'(ratio_out), int'(VEC[i][8:0]));
            chk("R2 odiv follow", int'(odiv_out), int'(VEC[i][10:9]));
            chk("R8 flag set", int'(par_mode), 1);
            par_load_n = 1'b1;
            cyc();
            ratio_pins = ~VEC[i][8:0];
            odiv_pins = ~VEC[i][10:9];
            cyc();
            chk("R3 ratio held", int'(ratio_out), int'(VEC[i][8:0]));
            chk("R3 odiv held", int'(odiv_out), int'(VEC[i][10:9]));
        end

        // R4/R5: shift a frame with null slot opposite its neighbours
        send_frame(2'b10, 1'b1, 2'b01, 9'd25);
        chk_cfg("R5 no load yet", 2'd0, 2'd3, 9'd0);
        ser_load = 1'b1;
        cyc();
        chk_cfg("R4 frame", 2'b10, 2'b01, 9'd25);
        chk("R8 flag clear", int'(par_mode), 0);
        ser_load = 1'b0;
        cyc();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        chk_cfg("R5 held after fall", 2'b10, 2'b01, 9'd25);

        // R6: transparent tracking while strobe stays high
        ser_load = 1'b1;
        cyc();
        chk_cfg("R6 load", sh[13:12], sh[10:9], sh[8:0]);
        send_bit(1'b1);
        chk_cfg("R6 track1", sh[13:12], sh[10:9], sh[8:0]);
        send_bit(1'b0);
        chk_cfg("R6 track2", sh[13:12], sh[10:9], sh[8:0]);
        ser_load = 1'b0;
        cyc();

        // R7: parallel activity between shifting and loading
        send_frame(2'b01, 1'b0, 2'b10, 9'd12);
        par_load_n = 1'b0;
        ratio_pins = 9'd300; odiv_pins = 2'd3;
        cyc();
        chk("R2 ratio mid", int'(ratio_out), 300);
        par_load_n = 1'b1;
        cyc();
        ser_load = 1'b1;
        cyc();
        chk_cfg("R7 frame intact", 2'b01, 2'b10, 9'd12);
        ser_load = 1'b0;
        cyc();

        // R9: both strobes at once
        par_load_n = 1'b0; ser_load = 1'b1;
        ratio_pins = 9'd100; odiv_pins = 2'd1;
        cyc();
        chk("R9 ratio", int'(ratio_out), 100);
        chk("R9 odiv", int'(odiv_out), 1);
        chk("R9 flag", int'(par_mode), 1);
        par_load_n = 1'b1; ser_load = 1'b0;
        cyc();

        // R1: reset mid-run, then serial load of a cleared register
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        sh = '0;
        chk_cfg("R1 rerun", 2'd0, 2'd0, 9'd32);
        ser_load = 1'b1;
        cyc();
        chk_cfg("R1 shift cleared", 2'd0, 2'd0, 9'd0);
        ser_load = 1'b0;
        cyc();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule